// File: doc/BRIEF.md
# Chunk Record Framer and Replay Checker

This block turns a run of payload words into a self-describing record chunk for an append-only log. Each chunk opens with a six-word header: a sync constant, a version/type word, the sequence number, the timestamp, the payload length in bytes, and a CRC over those five words. The payload words follow, then a separate CRC over the payload alone. If commit is requested for the chunk, a two-word commit marker comes last. The marker is a fixed constant followed by the committed sequence number. Several chunks can share one marker: only the last chunk of the group is sent with commit set, so the log takes fewer small metadata writes.

The second half of the block reads a chunk stream, whether replayed from storage or looped back. It trusts a chunk only when its header CRC matches, and otherwise hunts for the next sync word. It counts payload CRC failures and breaks in the sequence, and records the size of the last missing range. It reports the most recent sequence covered by a commit marker. Chunks accepted after that marker are only counted as pending, so replay rolls back to the reported point.

Top module: `chunk_record_framer`

## Requirements
- R1: After a start is accepted, the framer emits, one per valid cycle: 0x4B4E4843; a word with the chunk type in bits 7:0 (0 frame, 1 metadata, 2 marker), the version in bits 15:8 and zeros above; the sequence; the timestamp; and the payload length in bytes, equal to four times the word count.
- R2: The sixth word is the header CRC. It is CRC-32 over the five header words, using the reflected 0x04C11DB7 polynomial, an initial value of all ones and a final inversion. Each word is fed least significant byte first.
- R3: The payload words follow the header unchanged and in order. A cycle without valid payload emits nothing. The payload CRC comes next and covers only the payload words, using the same algorithm; for an empty payload it is 0x00000000.
- R4: With commit set, two more words follow: 0xC0DEC0A1, then the chunk's sequence number. `frm_last_o` marks the final word of the chunk: the sequence word of the marker, or the payload CRC when there is no commit. No word is emitted in the cycle after it.
- R5: A start request while the framer is busy is ignored and does not alter the chunk in progress.
- R6: In the checker, a chunk whose header CRC does not match increments the header-fail count. The chunk is skipped: it does not affect the sequence tracking or the pending count.
- R7: In the checker, an accepted chunk whose payload CRC does not match increments the CRC-fail count.
- R8: In the checker, when an accepted header's sequence is not the previous accepted sequence plus one, the gap count increments. The gap-size output then holds the number of missing sequence values.
- R9: In the checker, a commit marker sets the last committed sequence to its second word, sets the commit-seen flag and clears the pending count. Every accepted chunk increments the pending count, so trailing chunks without a marker leave the last committed sequence unchanged.
- R10: After reset the framer is idle with no valid output, and all checker counts, the gap size, the last committed sequence and the commit-seen flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new chunk (taken when idle) |
| type_i | input | 8 | Chunk type code |
| seq_i | input | 32 | Chunk sequence number |
| ts_i | input | 32 | Chunk timestamp |
| words_i | input | LEN_W | Payload length in 32-bit words |
| commit_i | input | 1 | Append a commit marker after this chunk |
| busy_o | output | 1 | Framer is emitting a chunk |
| pay_valid_i | input | 1 | Payload word available |
| pay_data_i | input | 32 | Payload word |
| pay_ready_o | output | 1 | Payload word taken this cycle when valid |
| frm_valid_o | output | 1 | Output word valid |
| frm_data_o | output | 32 | Output chunk word |
| frm_last_o | output | 1 | Final word of the chunk or batch |
| chk_valid_i | input | 1 | Checker input word valid |
| chk_data_i | input | 32 | Checker input word |
| hdr_fail_cnt_o | output | CNT_W | Chunks skipped for a bad header CRC |
| crc_fail_cnt_o | output | CNT_W | Accepted chunks with a bad payload CRC |
| gap_cnt_o | output | CNT_W | Sequence discontinuities seen |
| gap_size_o | output | 32 | Missing sequence values at the last gap |
| last_commit_seq_o | output | 32 | Sequence of the most recent commit marker |
| commit_seen_o | output | 1 | At least one commit marker seen |
| pend_chunks_o | output | CNT_W | Accepted chunks since the last commit marker |

## Verification
The assertions rely on two properties of the inputs. Start is offered only with a payload source that supplies exactly the announced number of words. The checker sees no payload word equal to either sync constant, and no sequence number that wraps. The stimulus keeps to this by tagging every payload word with the byte 0xA5 in bits 15:8, a byte neither constant has there. Sequences also stay far below the wrap point. Corruption is injected only by flipping one bit on the loop-back path, so every counter moves by at most one per chunk.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] SYNC_HDR = 32'h4B4E_4843;
  localparam logic [DW-1:0] SYNC_CMT = 32'hC0DE_C0A1;
  localparam logic [DW-1:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [DW-1:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam int unsigned HDR_WORDS = 6;

  typedef enum logic [2:0] {F_IDLE, F_HDR, F_PAY, F_PCRC, F_CMK, F_CSEQ} frm_st_e;
  typedef enum logic [2:0] {C_HUNT, C_HDR, C_PAY, C_PCRC, C_CSEQ} chk_st_e;

  // one 32-bit word, LSB-first, through a reflected CRC-32
  function automatic logic [DW-1:0] crc_word(input logic [DW-1:0] c, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = c ^ w;
    for (int i = 0; i < DW; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crf_framer.sv
module crf_framer
  import crf_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h01,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       type_i,
  input  logic [DW-1:0]    seq_i,
  input  logic [DW-1:0]    ts_i,
  input  logic [LEN_W-1:0] words_i,
  input  logic             commit_i,
  output logic             busy_o,
  input  logic             pay_valid_i,
  input  logic [DW-1:0]    pay_data_i,
  output logic             pay_ready_o,
  output logic             frm_valid_o,
  output logic [DW-1:0]    frm_data_o,
  output logic             frm_last_o
);
  localparam int unsigned IDX_W = $clog2(HDR_WORDS);
  localparam logic [IDX_W-1:0] IDX_CRC = IDX_W'(HDR_WORDS - 1);

  frm_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       type_q;
  logic [DW-1:0]    seq_q, ts_q, hcrc_q, pcrc_q;
  logic [LEN_W-1:0] words_q, cnt_q;
  logic             commit_q;
  logic [DW-1:0]    hdr_word, len_bytes;

  assign len_bytes = DW'({words_q, 2'b00});

  always_comb begin
    case (idx_q)
      IDX_W'(0): hdr_word = SYNC_HDR;
      IDX_W'(1): hdr_word = {16'h0000, VERSION, type_q};
      IDX_W'(2): hdr_word = seq_q;
      IDX_W'(3): hdr_word = ts_q;
      IDX_W'(4): hdr_word = len_bytes;
      default:   hdr_word = ~hcrc_q;
    endcase
  end

  always_comb begin
    frm_valid_o = 1'b1;
    frm_data_o  = '0;
    case (st_q)
      F_HDR:  frm_data_o = hdr_word;
      F_PAY:  begin frm_data_o = pay_data_i; frm_valid_o = pay_valid_i; end
      F_PCRC: frm_data_o = ~pcrc_q;
      F_CMK:  frm_data_o = SYNC_CMT;
      F_CSEQ: frm_data_o = seq_q;
      default: frm_valid_o = 1'b0;
    endcase
  end

  assign busy_o      = (st_q != F_IDLE);
  assign pay_ready_o = (st_q == F_PAY);
  assign frm_last_o  = (st_q == F_CSEQ) || (st_q == F_PCRC && !commit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE; idx_q <= '0; type_q <= '0; seq_q <= '0; ts_q <= '0;
      words_q <= '0; cnt_q <= '0; commit_q <= 1'b0;
      hcrc_q <= CRC_INIT; pcrc_q <= CRC_INIT;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) begin
          st_q <= F_HDR; idx_q <= '0; type_q <= type_i; seq_q <= seq_i; ts_q <= ts_i;
          words_q <= words_i; commit_q <= commit_i; cnt_q <= '0;
          hcrc_q <= CRC_INIT; pcrc_q <= CRC_INIT;
        end
        F_HDR: begin
          if (idx_q != IDX_CRC) begin
            hcrc_q <= crc_word(hcrc_q, hdr_word);
            idx_q  <= idx_q + 1'b1;
          end else begin
            st_q <= (words_q == '0) ? F_PCRC : F_PAY;
          end
        end
        F_PAY: if (pay_valid_i) begin
          pcrc_q <= crc_word(pcrc_q, pay_data_i);
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LEN_W'(words_q - 1'b1)) st_q <= F_PCRC;
        end
        F_PCRC: st_q <= commit_q ? F_CMK : F_IDLE;
        F_CMK:  st_q <= F_CSEQ;
        F_CSEQ: st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  AST_FIRST_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (frm_valid_o && frm_data_o == SYNC_HDR)); // R1
  AST_PAY_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_PCRC) |-> (cnt_q == words_q)); // R3
  AST_LAST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_last_o |=> !frm_valid_o); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !frm_last_o) |=> ($stable(seq_q) && busy_o)); // R5
endmodule

// File: rtl/crf_checker.sv
module crf_checker
  import crf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chk_valid_i,
  input  logic [DW-1:0]    chk_data_i,
  output logic [CNT_W-1:0] hdr_fail_cnt_o,
  output logic [CNT_W-1:0] crc_fail_cnt_o,
  output logic [CNT_W-1:0] gap_cnt_o,
  output logic [DW-1:0]    gap_size_o,
  output logic [DW-1:0]    last_commit_seq_o,
  output logic             commit_seen_o,
  output logic [CNT_W-1:0] pend_chunks_o
);
  localparam int unsigned IDX_W = $clog2(HDR_WORDS);
  localparam int unsigned WL_W = DW - 2;
  localparam logic [IDX_W-1:0] IDX_CRC = IDX_W'(HDR_WORDS - 1);

  chk_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    crc_q, seq_cap_q, last_seq_q;
  logic [WL_W-1:0]  wlen_q, cnt_q;
  logic             have_seq_q;
  logic [DW-1:0]    exp_seq;
  logic [DW-1:0]    d;

  assign d       = chk_data_i;
  assign exp_seq = last_seq_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= C_HUNT; idx_q <= '0; crc_q <= CRC_INIT; seq_cap_q <= '0; last_seq_q <= '0;
      wlen_q <= '0; cnt_q <= '0; have_seq_q <= 1'b0;
      hdr_fail_cnt_o <= '0; crc_fail_cnt_o <= '0; gap_cnt_o <= '0; gap_size_o <= '0;
      last_commit_seq_o <= '0; commit_seen_o <= 1'b0; pend_chunks_o <= '0;
    end else if (chk_valid_i) begin
      case (st_q)
        C_HUNT: begin
          if (d == SYNC_HDR) begin
            crc_q <= crc_word(CRC_INIT, d);
            idx_q <= IDX_W'(1);
            st_q  <= C_HDR;
          end else if (d == SYNC_CMT) begin
            st_q <= C_CSEQ;
          end
        end
        C_HDR: begin
          if (idx_q != IDX_CRC) begin
            crc_q <= crc_word(crc_q, d);
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(2)) seq_cap_q <= d;
            if (idx_q == IDX_W'(4)) wlen_q <= d[DW-1:2];
          end else if (d == ~crc_q) begin
            if (have_seq_q && seq_cap_q != exp_seq) begin
              gap_cnt_o  <= gap_cnt_o + 1'b1;
              gap_size_o <= seq_cap_q - exp_seq;
            end
            last_seq_q <= seq_cap_q;
            have_seq_q <= 1'b1;
            crc_q      <= CRC_INIT;
            cnt_q      <= '0;
            st_q       <= (wlen_q == '0) ? C_PCRC : C_PAY;
          end else begin
            hdr_fail_cnt_o <= hdr_fail_cnt_o + 1'b1;
            st_q           <= C_HUNT;
          end
        end
        C_PAY: begin
          crc_q <= crc_word(crc_q, d);
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == WL_W'(wlen_q - 1'b1)) st_q <= C_PCRC;
        end
        C_PCRC: begin
          if (d != ~crc_q) crc_fail_cnt_o <= crc_fail_cnt_o + 1'b1;
          pend_chunks_o <= pend_chunks_o + 1'b1;
          st_q          <= C_HUNT;
        end
        C_CSEQ: begin
          last_commit_seq_o <= d;
          commit_seen_o     <= 1'b1;
          pend_chunks_o     <= '0;
          st_q              <= C_HUNT;
        end
        default: st_q <= C_HUNT;
      endcase
    end
  end

  AST_HDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hdr_fail_cnt_o == $past(hdr_fail_cnt_o) ||
              hdr_fail_cnt_o == $past(hdr_fail_cnt_o) + 1'b1)); // R6
  AST_CRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (crc_fail_cnt_o == $past(crc_fail_cnt_o) ||
              crc_fail_cnt_o == $past(crc_fail_cnt_o) + 1'b1)); // R7
  AST_GAP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_cnt_o != $past(gap_cnt_o)) |-> (gap_size_o != '0)); // R8
  AST_SEEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_seen_o |=> commit_seen_o); // R9
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(commit_seen_o) |-> (pend_chunks_o == '0)); // R9
endmodule

// File: rtl/chunk_record_framer.sv
module chunk_record_framer
  import crf_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h01,
  parameter int unsigned LEN_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       type_i,
  input  logic [31:0]      seq_i,
  input  logic [31:0]      ts_i,
  input  logic [LEN_W-1:0] words_i,
  input  logic             commit_i,
  output logic             busy_o,
  input  logic             pay_valid_i,
  input  logic [31:0]      pay_data_i,
  output logic             pay_ready_o,
  output logic             frm_valid_o,
  output logic [31:0]      frm_data_o,
  output logic             frm_last_o,
  input  logic             chk_valid_i,
  input  logic [31:0]      chk_data_i,
  output logic [CNT_W-1:0] hdr_fail_cnt_o,
  output logic [CNT_W-1:0] crc_fail_cnt_o,
  output logic [CNT_W-1:0] gap_cnt_o,
  output logic [31:0]      gap_size_o,
  output logic [31:0]      last_commit_seq_o,
  output logic             commit_seen_o,
  output logic [CNT_W-1:0] pend_chunks_o
);
  crf_framer #(.VERSION(VERSION), .LEN_W(LEN_W)) u_framer (
    .clk_i, .rst_ni, .start_i, .type_i, .seq_i, .ts_i, .words_i, .commit_i,
    .busy_o, .pay_valid_i, .pay_data_i, .pay_ready_o,
    .frm_valid_o, .frm_data_o, .frm_last_o
  );

  crf_checker #(.CNT_W(CNT_W)) u_checker (
    .clk_i, .rst_ni, .chk_valid_i, .chk_data_i,
    .hdr_fail_cnt_o, .crc_fail_cnt_o, .gap_cnt_o, .gap_size_o,
    .last_commit_seq_o, .commit_seen_o, .pend_chunks_o
  );
endmodule

// File: tb/test_chunk_record_framer.sv
module test_chunk_record_framer;
  localparam int CLK_P = 10;
  localparam logic [31:0] SYNC_H = 32'h4B4E_4843;
  localparam logic [31:0] SYNC_C = 32'hC0DE_C0A1;
  localparam logic [7:0]  VER = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, commit = 1'b0, pay_valid = 1'b0;
  logic [7:0] typ = '0, nwords = '0;
  logic [31:0] seq = '0, ts = '0, pay_data = '0;
  logic busy, pay_ready, frm_valid, frm_last;
  logic [31:0] frm_data, chk_data, gap_size, last_commit;
  logic [15:0] hdr_fail, crc_fail, gap_cnt, pend;
  logic commit_seen;

  int checks = 0, failures = 0;
  int wcnt = 0, ncap = 0, cor_abs = -1;
  logic [31:0] cap [0:4095];
  logic        capl [0:4095];
  // reference model state
  int m_hdr = 0, m_crc = 0, m_gap = 0, m_pend = 0;
  logic [31:0] m_gsz = '0, m_lc = '0, m_last = '0;
  bit m_have = 0, m_seen = 0;

  always #(CLK_P/2) clk = ~clk;

  assign chk_data = frm_data ^ ((wcnt == cor_abs) ? 32'h1 : 32'h0);

  chunk_record_framer i_chunk_record_framer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .type_i(typ), .seq_i(seq), .ts_i(ts),
    .words_i(nwords), .commit_i(commit), .busy_o(busy), .pay_valid_i(pay_valid),
    .pay_data_i(pay_data), .pay_ready_o(pay_ready), .frm_valid_o(frm_valid),
    .frm_data_o(frm_data), .frm_last_o(frm_last), .chk_valid_i(frm_valid),
    .chk_data_i(chk_data), .hdr_fail_cnt_o(hdr_fail), .crc_fail_cnt_o(crc_fail),
    .gap_cnt_o(gap_cnt), .gap_size_o(gap_size), .last_commit_seq_o(last_commit),
    .commit_seen_o(commit_seen), .pend_chunks_o(pend)
  );

  always @(posedge clk) if (frm_valid) wcnt <= wcnt + 1;
  always @(negedge clk) if (frm_valid && ncap < 4096) begin
    cap[ncap] = frm_data; capl[ncap] = frm_last; ncap = ncap + 1;
  end

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {24'h0, w[8*b +: 8]};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] s, input int k);
    return {s[15:0], 8'hA5, 8'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input int ty, input logic [31:0] sq, input int nw, input bit cm,
                      input bit stall, input int cor);
    logic [31:0] exp [0:63];
    logic [31:0] hc, pc;
    int n, base, k, cyc;
    bit acc, bz;
    base = ncap;
    cor_abs = (cor < 0) ? -1 : wcnt + cor;
    exp[0] = SYNC_H; exp[1] = {16'h0, VER, 8'(ty)}; exp[2] = sq; exp[3] = sq * 100;
    exp[4] = 32'(nw * 4);
    hc = 32'hFFFFFFFF;
    for (int i = 0; i < 5; i++) hc = crc_b(hc, exp[i]);
    exp[5] = ~hc;
    pc = 32'hFFFFFFFF;
    for (int i = 0; i < nw; i++) begin exp[6+i] = pat(sq, i); pc = crc_b(pc, exp[6+i]); end
    exp[6+nw] = ~pc;
    n = 7 + nw;
    if (cm) begin exp[n] = SYNC_C; exp[n+1] = sq; n = n + 2; end
    @(posedge clk); #1;
    start = 1; typ = 8'(ty); seq = sq; ts = sq * 100; nwords = 8'(nw); commit = cm;
    @(posedge clk); #1;
    // R5: a start while busy with other fields must be ignored
    seq = sq + 77; nwords = 8'(nw + 3); commit = ~cm;
    @(posedge clk); #1;
    start = 0;
    k = 0; cyc = 0;
    do begin
      pay_valid = stall ? cyc[0] : 1'b1;
      pay_data = pat(sq, k);
      @(negedge clk);
      acc = pay_ready && pay_valid; bz = busy;
      @(posedge clk); #1;
      if (acc) k++;
      cyc++;
    end while (bz);
    pay_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    cor_abs = -1;
    chk((ncap - base) == n, "R5 word count", 32'(ncap - base), 32'(n));
    for (int i = 0; i < n && i < ncap - base; i++) begin
      string r;
      r = (i < 5) ? "R1 header" : (i == 5) ? "R2 header crc" : (i < 7 + nw) ? "R3 payload" : "R4 commit marker";
      chk(cap[base+i] == exp[i], r, cap[base+i], exp[i]);
    end
    chk(capl[base+n-1] == 1'b1, "R4 last flag", 32'(capl[base+n-1]), 32'd1);
    // reference model for the checker
    if (cor >= 0 && cor < 6) m_hdr++;
    else begin
      if (m_have && sq != m_last + 1) begin m_gap++; m_gsz = sq - m_last - 1; end
      m_last = sq; m_have = 1;
      if (cor >= 6 && cor <= 6 + nw) m_crc++;
      m_pend++;
      if (cm) begin m_lc = sq; m_pend = 0; m_seen = 1; end
    end
    @(negedge clk);
    chk(hdr_fail == 16'(m_hdr), "R6 header fail count", 32'(hdr_fail), 32'(m_hdr));
    chk(crc_fail == 16'(m_crc), "R7 crc fail count", 32'(crc_fail), 32'(m_crc));
    chk(gap_cnt == 16'(m_gap), "R8 gap count", 32'(gap_cnt), 32'(m_gap));
    chk(gap_size == m_gsz, "R8 gap size", gap_size, m_gsz);
    chk(last_commit == m_lc, "R9 last commit", last_commit, m_lc);
    chk(commit_seen == m_seen, "R9 commit seen", 32'(commit_seen), 32'(m_seen));
    chk(pend == 16'(m_pend), "R9 pending", 32'(pend), 32'(m_pend));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !frm_valid, "R10 framer idle", 32'({busy, frm_valid}), 32'd0);
    chk(hdr_fail == 0 && crc_fail == 0 && gap_cnt == 0 && pend == 0, "R10 counts",
        32'({hdr_fail, crc_fail} | {gap_cnt, pend}), 32'd0);
    chk(gap_size == 0 && last_commit == 0 && !commit_seen, "R10 commit state",
        last_commit | gap_size, 32'd0);
    rst_n = 1;
    send(0, 32'd10, 3, 1, 0, -1);        // single committed frame
    send(1, 32'd11, 0, 0, 1, -1);        // empty metadata, batched
    send(2, 32'd12, 2, 1, 0, -1);        // batch closes here
    send(0, 32'd15, 4, 1, 1, -1);        // R8 gap of two
    send(0, 32'd16, 2, 1, 0, 6);         // R7 payload corrupted
    send(1, 32'd17, 1, 0, 0, 2);         // R6 header corrupted, skipped
    send(0, 32'd18, 5, 0, 1, -1);        // R9 trailing uncommitted
    send(0, 32'd19, 1, 0, 0, 7);         // R7 payload crc word corrupted
    for (int nw = 0; nw <= 6; nw++)
      for (int st = 0; st < 2; st++)
        send(nw % 3, 32'(20 + 2 * nw + st), nw, (st == 1), bit'(st), -1);
    summary();
    $finish;
  end
endmodule